// File: doc/BRIEF.md
# Synchronous Shutter Exposure Sequencer

This block paces one global-shutter exposure of a CMOS image core with a single integration slope. A programmable divider turns the system clock into a one-cycle enable, the tick. All phase lengths and the integration timer are counted in ticks. The host, or an external counter, supplies two separate pulses: one to open the shutter and one to close it. While either pulse is held, the sequencer is suspended. When the opening pulse is released, the sequencer asserts the core reset for four ticks and strobes the begin-integration control on the last cycle of that reset. In parallel, the timer counts ticks up to the programmed exposure length and then raises a one-tick timeout. The timeout can be looped back onto the closing input. When the closing pulse is released, the sequencer spends two ticks preparing the core for readout and then reports that the core is readable.

The controller has seven named states. IDLE is the state after reset. ARM is the suspended state while the opening pulse is held. CORE_RST holds the core reset for four ticks. INTEG is the integration state. HALT is the suspended state while the closing pulse is held. PREP is the two-tick readout preparation. READY means the core is readable.

The transitions are as follows:
- IDLE or READY go to ARM when start is sampled high.
- ARM goes to CORE_RST when start is sampled low.
- CORE_RST goes to INTEG on its fourth tick.
- CORE_RST or INTEG go to HALT when stop is sampled high.
- HALT goes to PREP when stop is sampled low.
- PREP goes to READY on its second tick.
- A synchronous reset returns every state to IDLE.

Top module: `shutter_seq`

## Requirements
- R1: With ratio value N (N = 0 treated as 1), a tick occurs once every N system-clock cycles.
- R2: start_i and stop_i are sampled on rising clock edges. busy_o rises on the first edge that samples start_i high in IDLE or READY.
- R3: While start_i stays high in ARM, core_rst_o stays low and the sequencer does not advance.
- R4: After start_i is sampled low, core_rst_o is high for exactly 4 ticks. With the free-running divider this is between 3N+1 and 4N cycles.
- R5: int_begin_o is high for exactly one cycle, which is the last cycle in which core_rst_o is high.
- R6: The timer counts ticks starting with the first tick after start_i is sampled low. timeout_o rises on tick max(T,1), where T is int_time_i. Measured against the fall of core_rst_o, the rise is offset by (max(T,1)-4)·N cycles.
- R7: timeout_o stays high for exactly one tick period (N cycles) and then falls, even when the sequencer has left integration.
- R8: While stop_i stays high in HALT, the sequencer is suspended. After the edge that samples stop_i low, readable_o rises after 2 ticks, which is between N+1 and 2N cycles.
- R9: A start_i pulse in CORE_RST, INTEG, HALT or PREP is ignored (core_rst_o does not reassert) and sets proto_err_o.
- R10: A stop_i pulse in IDLE or READY is ignored (the readable and busy outputs keep their values) and sets proto_err_o. proto_err_o then stays high until reset.
- R11: busy_o falls on the same edge on which readable_o rises.
- R12: A start from READY begins a fresh frame with the timer cleared, so the R4 to R8 timing repeats. Feeding timeout_o back to stop_i ends the exposure.
- R13: A synchronous reset returns the block to IDLE with every output low and the timer cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Shutter-open pulse |
| stop_i | input | 1 | Shutter-close pulse |
| div_ratio_i | input | DIV_W | Tick divider ratio (0 acts as 1) |
| int_time_i | input | TIME_W | Integration length in ticks |
| core_rst_o | output | 1 | Core reset control |
| int_begin_o | output | 1 | Begin-integration strobe |
| timeout_o | output | 1 | One-tick integration timeout |
| readable_o | output | 1 | Core is in the readable state |
| busy_o | output | 1 | Exposure in progress |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the block with a 2-bit ratio and a 3-bit integration register. This makes it possible to sweep every ratio value, including the 0 alias, against every integration length from 0 to 7. Each combination runs two back-to-back frames, so timer clearing between frames is exercised as well. Closing is driven both by an external stop pulse and by looping the timeout back, and the bench computes each phase window from the tick spacing. The small widths also put the case where the timeout falls inside the core-reset phase (T below 4) within reach, as well as late start pulses and stop pulses in the wrong state.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_ARM,
        SH_CORE_RST,
        SH_INTEG,
        SH_HALT,
        SH_PREP,
        SH_READY
    } shutter_state_e;

    localparam int RST_TICKS  = 4;
    localparam int PREP_TICKS = 2;

endpackage

// File: rtl/shutter_div.sv
module shutter_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim    = (ratio_i == '0) ? '0 : ratio_i - 1'b1;
    assign tick_o = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // two ticks never sit side by side while the ratio stays above 1
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_o && ratio_i > 1) |=> (!tick_o || ratio_i < 2));

endmodule

// File: rtl/shutter_timer.sv
module shutter_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [TIME_W-1:0] limit_i,
    output logic              timeout_o
);
    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W:0]   nxt;
    logic              fired_q;
    logic              to_q;

    assign nxt       = {1'b0, cnt_q} + (TIME_W+1)'(1);
    assign timeout_o = to_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            to_q    <= 1'b0;
        end else if (tick_i) begin
            to_q <= 1'b0;
            if (run_i && !fired_q) begin
                cnt_q <= nxt[TIME_W-1:0];
                if (nxt >= {1'b0, limit_i}) begin
                    fired_q <= 1'b1;
                    to_q    <= 1'b1;
                end
            end
        end
    end

    // timeout only starts on a counted tick
    assert_to_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> $past(tick_i && run_i));

    // timeout persists until the next tick
    assert_to_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (timeout_o && !tick_i && !clr_i) |=> timeout_o);

endmodule

// File: rtl/shutter_fsm.sv
module shutter_fsm
    import shutter_pkg::*;
#(
    parameter int RST_LEN  = RST_TICKS,
    parameter int PREP_LEN = PREP_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    output logic core_rst_o,
    output logic int_begin_o,
    output logic readable_o,
    output logic busy_o,
    output logic err_o,
    output logic tmr_clr_o,
    output logic tmr_run_o
);
    localparam int PH_MAX = (RST_LEN > PREP_LEN) ? RST_LEN : PREP_LEN;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    shutter_state_e state_q, state_d;
    logic [PH_W-1:0] phase_q;
    logic            err_q;
    logic            rst_done, prep_done, err_set;

    assign rst_done  = tick_i && (phase_q == PH_W'(RST_LEN - 1));
    assign prep_done = tick_i && (phase_q == PH_W'(PREP_LEN - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE,
            SH_READY:    if (start_i)     state_d = SH_ARM;
            SH_ARM:      if (!start_i)    state_d = SH_CORE_RST;
            SH_CORE_RST: if (stop_i)      state_d = SH_HALT;
                         else if (rst_done) state_d = SH_INTEG;
            SH_INTEG:    if (stop_i)      state_d = SH_HALT;
            SH_HALT:     if (!stop_i)     state_d = SH_PREP;
            SH_PREP:     if (prep_done)   state_d = SH_READY;
            default:                      state_d = SH_IDLE;
        endcase
    end

    always_comb begin
        err_set = 1'b0;
        unique case (state_q)
            SH_CORE_RST, SH_INTEG, SH_HALT, SH_PREP: err_set = start_i;
            SH_IDLE, SH_READY:                       err_set = stop_i;
            default:                                 err_set = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            phase_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                phase_q <= '0;
            else if (tick_i && (state_q == SH_CORE_RST || state_q == SH_PREP))
                phase_q <= phase_q + 1'b1;
            if (err_set) err_q <= 1'b1;
        end
    end

    always_comb begin
        core_rst_o  = (state_q == SH_CORE_RST);
        int_begin_o = (state_q == SH_CORE_RST) && rst_done && !stop_i;
        readable_o  = (state_q == SH_READY);
        busy_o      = (state_q != SH_IDLE) && (state_q != SH_READY);
        tmr_clr_o   = (state_q == SH_ARM);
        tmr_run_o   = (state_q == SH_CORE_RST) || (state_q == SH_INTEG);
        err_o       = err_q;
    end

    assert_arm_suspend_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SH_ARM && start_i) |=> (state_q == SH_ARM));

    assert_halt_suspend_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == SH_HALT && stop_i) |=> (state_q == SH_HALT));

    assert_rst_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) |-> $past(state_q == SH_ARM && !start_i));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    assert_ready_after_prep_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(readable_o) |-> ($past(state_q == SH_PREP) && !busy_o));

endmodule

// File: rtl/shutter_seq.sv
module shutter_seq #(
    parameter int DIV_W  = 4,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [DIV_W-1:0]  div_ratio_i,
    input  logic [TIME_W-1:0] int_time_i,
    output logic              core_rst_o,
    output logic              int_begin_o,
    output logic              timeout_o,
    output logic              readable_o,
    output logic              busy_o,
    output logic              proto_err_o
);
    logic tick;
    logic tmr_clr, tmr_run;

    shutter_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (div_ratio_i),
        .tick_o  (tick)
    );

    shutter_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .tick_i      (tick),
        .core_rst_o  (core_rst_o),
        .int_begin_o (int_begin_o),
        .readable_o  (readable_o),
        .busy_o      (busy_o),
        .err_o       (proto_err_o),
        .tmr_clr_o   (tmr_clr),
        .tmr_run_o   (tmr_run)
    );

    shutter_timer #(.TIME_W(TIME_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .tick_i    (tick),
        .limit_i   (int_time_i),
        .timeout_o (timeout_o)
    );

    // a fresh frame never begins with a stale timeout (R12)
    assert_clean_frame_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) |-> !timeout_o);

endmodule

// File: tb/test_shutter_seq.sv
module test_shutter_seq;
    localparam int DW = 2;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_drv = 1'b0, stop_drv = 1'b0, loop_mode = 1'b0;
    logic [DW-1:0] ratio = '0;
    logic [TW-1:0] itime = '0;
    logic stop_w;
    logic core_rst, int_begin, tmo, readable, busy, perr;

    assign stop_w = loop_mode ? tmo : stop_drv;

    shutter_seq #(.DIV_W(DW), .TIME_W(TW)) i_shutter_seq (
        .clk(clk), .rst(rst), .start_i(start_drv), .stop_i(stop_w),
        .div_ratio_i(ratio), .int_time_i(itime),
        .core_rst_o(core_rst), .int_begin_o(int_begin), .timeout_o(tmo),
        .readable_o(readable), .busy_o(busy), .proto_err_o(perr)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    int rst_rise, rst_fall, rst_rises, ib_cnt, ib_cyc, to_rise, to_fall;
    int rd_rise, busy_rise, busy_fall, susp_bad;
    bit p_rst = 0, p_to = 0, p_rd = 0, p_busy = 0;

    task automatic arm_rec();
        rst_rise = -1; rst_fall = -1; rst_rises = 0; ib_cnt = 0; ib_cyc = -1;
        to_rise = -1; to_fall = -1; rd_rise = -1; busy_rise = -1; busy_fall = -1;
        susp_bad = 0;
    endtask

    always @(negedge clk) begin
        if (core_rst && !p_rst) begin rst_rise = cyc; rst_rises++; end
        if (!core_rst && p_rst) rst_fall = cyc;
        if (int_begin) begin ib_cnt++; ib_cyc = cyc; end
        if (tmo && !p_to) to_rise = cyc;
        if (!tmo && p_to) to_fall = cyc;
        if (readable && !p_rd) rd_rise = cyc;
        if (busy && !p_busy) busy_rise = cyc;
        if (!busy && p_busy) busy_fall = cyc;
        if (start_drv && core_rst) susp_bad++;
        p_rst = core_rst; p_to = tmo; p_rd = readable; p_busy = busy;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (N=%0d T=%0d loop=%0d)",
                     req, act, exp, ratio, itime, loop_mode);
        end
    endtask

    task automatic wait_set(ref int v, input string req);
        int g = 0;
        while (v < 0 && g < 400) begin @(posedge clk); g++; end
        if (v < 0) check(1'b0, req, v, 0);
    endtask

    task automatic do_reset();
        @(posedge clk); #2 rst = 1'b1;
        start_drv = 1'b0; stop_drv = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    task automatic frame(input bit inj, input bit exp_err);
        int n, k, s, stopf;
        n = (ratio == 0) ? 1 : int'(ratio);
        k = (itime == 0) ? 1 : int'(itime);
        arm_rec();
        @(posedge clk); #2 start_drv = 1'b1; s = cyc;
        repeat (3) @(posedge clk);
        #2 start_drv = 1'b0;
        wait_set(rst_fall, "R4 core reset never ended");
        if (inj) begin
            @(posedge clk); #2 start_drv = 1'b1;
            @(posedge clk); #2 start_drv = 1'b0;
        end
        if (!loop_mode) begin
            wait_set(to_fall, "R7 timeout never ended");
            repeat (2) @(posedge clk);
            #2 stop_drv = 1'b1;
            repeat (4) @(posedge clk);
            #2 stop_drv = 1'b0; stopf = cyc;
        end
        wait_set(rd_rise, "R8 readable never rose");
        if (loop_mode) stopf = to_fall;
        @(negedge clk);
        check(busy_rise == s + 1, "R2 busy rise cycle", busy_rise, s + 1);
        check(susp_bad == 0, "R3 core reset while start held", susp_bad, 0);
        check(rst_fall - rst_rise >= 3*n + 1 && rst_fall - rst_rise <= 4*n,
              "R4 core reset width (lower bound shown)", rst_fall - rst_rise, 3*n + 1);
        check(ib_cnt == 1 && ib_cyc == rst_fall - 1, "R5 int_begin strobe cycle",
              ib_cyc, rst_fall - 1);
        check(to_rise - rst_fall == (k - 4) * n, "R6 timeout offset", to_rise - rst_fall,
              (k - 4) * n);
        check(to_fall - to_rise == n, "R7 R1 timeout width", to_fall - to_rise, n);
        check(rd_rise - stopf >= n + 2 && rd_rise - stopf <= 2*n + 1,
              "R8 readable delay (lower bound shown)", rd_rise - stopf, n + 2);
        check(busy_fall == rd_rise, "R11 busy fall vs readable", busy_fall, rd_rise);
        check(rst_rises == 1, "R9 core reset re-entries", rst_rises, 1);
        check(perr == exp_err, "R9 R10 error flag", perr, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R13 reset state
        check({core_rst, int_begin, tmo, readable, busy, perr} == 6'b0,
              "R13 reset outputs", {core_rst, int_begin, tmo, readable, busy, perr}, 0);

        // R10 stop in IDLE ignored
        @(posedge clk); #2 stop_drv = 1'b1;
        repeat (2) @(posedge clk); #2 stop_drv = 1'b0;
        @(negedge clk);
        check(!busy && !readable && !core_rst, "R10 idle stop ignored",
              {busy, readable, core_rst}, 0);
        check(perr == 1'b1, "R10 idle stop error", perr, 1);

        // sweeps: external stop for every T, loopback for T>=4; two frames each
        for (int r = 0; r < 4; r++) begin
            for (int t = 0; t < 8; t++) begin
                for (int lp = 0; lp < 2; lp++) begin
                    if (lp == 1 && t < 4) continue;
                    ratio = DW'(r); itime = TW'(t); loop_mode = lp[0];
                    do_reset();
                    frame(lp == 0 && t[0], lp == 0 && t[0]);
                    // R12 second frame from READY, timer freshly cleared
                    frame(1'b0, lp == 0 && t[0]);
                end
            end
        end

        // R10 stop in READY ignored
        loop_mode = 1'b0; ratio = 2'd2; itime = 3'd5;
        do_reset();
        frame(1'b0, 1'b0);
        @(posedge clk); #2 stop_drv = 1'b1;
        repeat (2) @(posedge clk); #2 stop_drv = 1'b0;
        @(negedge clk);
        check(readable && !busy, "R10 ready stop ignored", readable, 1);
        check(perr == 1'b1, "R10 ready stop error", perr, 1);

        // R13 reset mid-exposure
        arm_rec();
        @(posedge clk); #2 start_drv = 1'b1;
        @(posedge clk); #2 start_drv = 1'b0;
        wait_set(rst_fall, "R13 core reset never ended");
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check({core_rst, tmo, readable, busy, perr} == 5'b0, "R13 mid-run reset",
              {core_rst, tmo, readable, busy, perr}, 0);
        frame(1'b0, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule